// File: doc/BRIEF.md
# Memory-Mapped PCI Configuration Controller

This block sits behind a CPU register window and turns each word load or store inside that window into a configuration access on PCI bus 0. The window offset selects the target: bits 15:12 give the device, bits 10:8 give the function, bits 7:0 give the register, and bit 11 plays no part. Accesses to populated external slots go out on a request/response port, and the CPU waits until the response arrives or a timeout expires. Slots with no device present are answered locally, with the conventional all-ones identity.

The controller also holds its own host-bridge function, which always answers at device 15, function 0, with a fixed vendor and product identity. This function has two base address registers. The first must stay at zero for main memory to map correctly, and any non-zero write to it raises a sticky error flag. The second can be set only once, and setting it opens a byte-swapped aperture. The block publishes only the aperture base and an enable; the swap data path is built elsewhere.

Top module: `pcfg_ctrl`

## Requirements
- R1: The target is decoded from the offset as device = cpu_addr[15:12], function = cpu_addr[10:8] and register = cpu_addr[7:0]. cpu_addr[11] is ignored. A forwarded request carries these three fields on dn_dev, dn_func and dn_reg.
- R2: A read of register 0x00 at device 15, function 0, returns 0x401310EE, with the product ID in bits 31:16 and the vendor ID in bits 15:0. Every bridge access completes in the cycle it is presented (cpu_ready is high in that cycle).
- R3: If dn_present is low, a read of register 0x00 returns 0xFFFFFFFF and a read of any other register returns 0. Either read completes in its first cycle and issues no downstream request.
- R4: A write to a slot whose dn_present is low completes in its first cycle and issues no downstream request.
- R5: A write to bridge register 0x10 always stores the value, and a read returns it. A non-zero value sets bar0_err. bar0_err stays high until err_clear is pulsed. When a set and a clear fall in the same cycle, the set wins.
- R6: A write to bridge register 0x14 is accepted only while that register holds zero. An accepted write stores the value, drives it on swap_base and sets swap_en permanently. Writes made while the register is non-zero change nothing.
- R7: Bridge registers other than 0x00, 0x10 and 0x14 read as 0 and ignore writes.
- R8: An access to a slot whose dn_present is high, other than device 15 function 0, raises dn_req_valid for exactly one cycle. The request carries dn_req_write and dn_wdata. cpu_ready goes high in the cycle dn_rsp_valid is high, and a read returns dn_rsp_rdata.
- R9: If no response arrives, the forwarded access completes in its 255th waiting cycle, and a read returns 0xFFFFFFFF. A response that arrives in that same cycle is used instead.
- R10: After reset both base registers read 0, and swap_en, swap_base and bar0_err are 0.
- R11: Device 15 function 0 is always served by the internal bridge, even when dn_present is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_valid | input | 1 | CPU access request, held until cpu_ready |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Offset within the configuration window |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Access completes at this clock edge |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| dn_req_valid | output | 1 | One-cycle downstream request strobe |
| dn_req_write | output | 1 | Downstream request is a write |
| dn_dev | output | 4 | Decoded device number |
| dn_func | output | 3 | Decoded function number |
| dn_reg | output | 8 | Decoded register offset |
| dn_wdata | output | 32 | Downstream write data |
| dn_present | input | 1 | A device exists at dn_dev/dn_func |
| dn_rsp_valid | input | 1 | Downstream response |
| dn_rsp_rdata | input | 32 | Downstream read data |
| err_clear | input | 1 | Clears bar0_err |
| bar0_err | output | 1 | Sticky: non-zero value written to bridge BAR0 |
| swap_en | output | 1 | Byte-swapped aperture is open |
| swap_base | output | 32 | Aperture base address (bridge BAR1) |

## Verification
The hardest case to reach from the ports is the timeout boundary. A response that lands in exactly the 255th waiting cycle must win over the all-ones default, and one cycle of skew either way would go unseen. The downstream model in the bench answers after a programmable delay. The bench runs it once with no response at all, and once with the delay set so the response coincides with the expiry cycle, and checks both the returned data and the number of wait cycles. The write-once lock on BAR1 is reached by first writing zero, which opens the aperture but leaves the register unlocked, and then writing two different non-zero values.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
   typedef enum logic {FWD_IDLE = 1'b0, FWD_WAIT = 1'b1} fwd_state_t;

   localparam logic [7:0] REG_IDENT = 8'h00;
   localparam logic [7:0] REG_BASE0 = 8'h10;
   localparam logic [7:0] REG_BASE1 = 8'h14;
endpackage

// File: rtl/pcfg_decode.sv
module pcfg_decode #(
   parameter int ADDR_W     = 16,
   parameter int BRIDGE_DEV = 15,
   parameter int BRIDGE_FN  = 0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [3:0]        dev,
   output logic [2:0]        func,
   output logic [7:0]        regno,
   output logic              hit_bridge
);
   wire unused_bits = ^{addr[11], addr >> 16};

   assign dev        = addr[15:12];
   assign func       = addr[10:8];
   assign regno      = addr[7:0];
   assign hit_bridge = (dev == 4'(BRIDGE_DEV)) && (func == 3'(BRIDGE_FN));
endmodule

// File: rtl/pcfg_bridge.sv
module pcfg_bridge
   import pcfg_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter logic [15:0] VENDOR_ID  = 16'h10EE,
   parameter logic [15:0] PRODUCT_ID = 16'h4013
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        regno,
   input  logic [DATA_W-1:0] wdata,
   input  logic              err_clear,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] base1,
   output logic              err,
   output logic              swap_en
);
   logic [DATA_W-1:0] base0;
   logic              set_err;

   assign set_err = wr_en && (regno == REG_BASE0) && (wdata != '0);

   always_comb begin
      case (regno)
         REG_IDENT: rdata = DATA_W'({PRODUCT_ID, VENDOR_ID});
         REG_BASE0: rdata = base0;
         REG_BASE1: rdata = base1;
         default:   rdata = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base0   <= '0;
         base1   <= '0;
         err     <= 1'b0;
         swap_en <= 1'b0;
      end else begin
         if (wr_en && regno == REG_BASE0)
            base0 <= wdata;
         if (wr_en && regno == REG_BASE1 && base1 == '0) begin
            base1   <= wdata;
            swap_en <= 1'b1;
         end
         if (set_err)
            err <= 1'b1;
         else if (err_clear)
            err <= 1'b0;
      end
   end

   // R6: once non-zero, the aperture base never moves
   a_r6_base1_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (base1 != '0) |=> $stable(base1));
   // R6: aperture enable is sticky
   a_r6_swap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      swap_en |=> swap_en);
   // R5: non-zero BAR0 store raises the error flag
   a_r5_err_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && regno == REG_BASE0 && wdata != '0) |=> err);
   // R5: clear without a new error drops the flag
   a_r5_err_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clear && !(wr_en && regno == REG_BASE0)) |=> !err);
endmodule

// File: rtl/pcfg_fwd.sv
module pcfg_fwd
   import pcfg_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int TIMEOUT = 255
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_write,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              req_valid,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata
);
   localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT + 1) : 1;

   fwd_state_t state;
   logic       expire;

   assign busy      = (state == FWD_WAIT);
   assign req_valid = start && !busy;
   assign done      = busy && (rsp_valid || expire);
   assign rdata     = is_write ? '0 : (rsp_valid ? rsp_data : '1);

   generate
      if (TIMEOUT > 0) begin : g_timer
         logic [CNT_W-1:0] wait_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               wait_cnt <= '0;
            else if (req_valid)
               wait_cnt <= '0;
            else if (busy && !done)
               wait_cnt <= wait_cnt + 1'b1;
         end
         assign expire = (wait_cnt == CNT_W'(TIMEOUT - 1));

         // R9: the wait never runs past the timeout window
         a_r9_window: assert property (@(posedge clk) disable iff (!rst_n)
            busy |-> (wait_cnt < CNT_W'(TIMEOUT)));
      end else begin : g_no_timer
         assign expire = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= FWD_IDLE;
      else if (req_valid)
         state <= FWD_WAIT;
      else if (done)
         state <= FWD_IDLE;
   end

   // R8: one request strobe per forwarded access
   a_r8_single_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> !req_valid);
   // R8: a response ends the wait
   a_r8_rsp_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rsp_valid) |=> !busy);
endmodule

// File: rtl/pcfg_ctrl.sv
module pcfg_ctrl
   import pcfg_pkg::*;
#(
   parameter int          ADDR_W     = 16,
   parameter int          DATA_W     = 32,
   parameter int          TIMEOUT    = 255,
   parameter int          BRIDGE_DEV = 15,
   parameter int          BRIDGE_FN  = 0,
   parameter logic [15:0] VENDOR_ID  = 16'h10EE,
   parameter logic [15:0] PRODUCT_ID = 16'h4013,
   parameter longint      APER_SIZE  = 64'h1000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_write,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              dn_req_valid,
   output logic              dn_req_write,
   output logic [3:0]        dn_dev,
   output logic [2:0]        dn_func,
   output logic [7:0]        dn_reg,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic              dn_present,
   input  logic              dn_rsp_valid,
   input  logic [DATA_W-1:0] dn_rsp_rdata,
   input  logic              err_clear,
   output logic              bar0_err,
   output logic              swap_en,
   output logic [DATA_W-1:0] swap_base
);
   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("pcfg_ctrl: configuration registers are 32 bits");
      end
      if (ADDR_W < 16) begin : g_bad_addr
         $error("pcfg_ctrl: window offset needs at least 16 bits");
      end
      if (BRIDGE_DEV > 15 || BRIDGE_FN > 7) begin : g_bad_slot
         $error("pcfg_ctrl: bridge slot out of range");
      end
      if (APER_SIZE <= 0 || (APER_SIZE & (APER_SIZE - 1)) != 0) begin : g_bad_aper
         $error("pcfg_ctrl: aperture size must be a power of two");
      end
   endgenerate

   logic              hit_bridge, fwd_busy, fwd_done, start, absent;
   logic [DATA_W-1:0] br_rdata, fwd_rdata;

   pcfg_decode #(.ADDR_W(ADDR_W), .BRIDGE_DEV(BRIDGE_DEV), .BRIDGE_FN(BRIDGE_FN)) u_dec (
      .addr(cpu_addr), .dev(dn_dev), .func(dn_func), .regno(dn_reg),
      .hit_bridge(hit_bridge));

   pcfg_bridge #(.DATA_W(DATA_W), .VENDOR_ID(VENDOR_ID), .PRODUCT_ID(PRODUCT_ID)) u_br (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cpu_valid && cpu_write && hit_bridge && !fwd_busy),
      .regno(dn_reg), .wdata(cpu_wdata), .err_clear(err_clear),
      .rdata(br_rdata), .base1(swap_base), .err(bar0_err), .swap_en(swap_en));

   assign absent = !hit_bridge && !dn_present;
   assign start  = cpu_valid && !hit_bridge && dn_present;

   pcfg_fwd #(.DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) u_fwd (
      .clk(clk), .rst_n(rst_n), .start(start), .is_write(cpu_write),
      .rsp_valid(dn_rsp_valid), .rsp_data(dn_rsp_rdata),
      .req_valid(dn_req_valid), .busy(fwd_busy), .done(fwd_done),
      .rdata(fwd_rdata));

   assign dn_req_write = cpu_write;
   assign dn_wdata     = cpu_wdata;
   assign cpu_ready    = fwd_busy ? fwd_done : (cpu_valid && (hit_bridge || absent));

   always_comb begin
      if (fwd_busy)
         cpu_rdata = fwd_rdata;
      else if (hit_bridge)
         cpu_rdata = br_rdata;
      else
         cpu_rdata = (dn_reg == REG_IDENT) ? '1 : '0;
   end

   // R3/R4: an absent slot completes at once without going downstream
   a_r3_absent_local: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && !fwd_busy && !hit_bridge && !dn_present) |-> (cpu_ready && !dn_req_valid));
   // R11: the internal bridge never produces a downstream request
   a_r11_bridge_local: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && !fwd_busy && hit_bridge) |-> (cpu_ready && !dn_req_valid));
   // R8: a request is never answered in the cycle it is issued
   a_r8_no_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req_valid |-> !cpu_ready);
endmodule

// File: tb/sim_pcfg_ctrl.sv
module sim_pcfg_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_valid = 1'b0, cpu_write = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_ready;
   logic [31:0] cpu_rdata;
   logic        dn_req_valid, dn_req_write;
   logic [3:0]  dn_dev;
   logic [2:0]  dn_func;
   logic [7:0]  dn_reg;
   logic [31:0] dn_wdata;
   logic        dn_present;
   logic        dn_rsp_valid = 1'b0;
   logic [31:0] dn_rsp_rdata = '0;
   logic        err_clear = 1'b0;
   logic        bar0_err, swap_en;
   logic [31:0] swap_base;

   int total = 0, bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;   // 250 MHz

   pcfg_ctrl u0 (.*);

   // downstream slots: dev 2 fn 0, dev 9 any fn, dev 15 any fn
   assign dn_present = (dn_dev == 4'd2 && dn_func == 3'd0) || dn_dev == 4'd9 || dn_dev == 4'd15;

   function automatic logic [31:0] slot_data(logic [3:0] d, logic [2:0] f, logic [7:0] r);
      return {8'h5A, 9'h0, d, f, r};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // downstream model
   int          rsp_delay = 0;   // -1 = never answer
   int          nreq = 0;
   bit          pend = 0;
   int          cnt = 0;
   logic [31:0] pend_data, cap_wdata;
   logic [3:0]  cap_dev;
   logic [2:0]  cap_func;
   logic [7:0]  cap_reg;
   logic        cap_wr;
   initial forever begin
      @(negedge clk);
      dn_rsp_valid = 1'b0;
      if (pend) begin
         if (cnt == 0) begin
            dn_rsp_valid = 1'b1; dn_rsp_rdata = pend_data; pend = 0;
         end else cnt--;
      end
      #1;
      if (rst_n && dn_req_valid) begin
         nreq++;
         cap_dev = dn_dev; cap_func = dn_func; cap_reg = dn_reg;
         cap_wr = dn_req_write; cap_wdata = dn_wdata;
         if (rsp_delay >= 0) begin
            pend = 1; cnt = rsp_delay; pend_data = slot_data(dn_dev, dn_func, dn_reg);
         end
      end
   end

   // scoreboard
   logic [31:0] exp_q[$];
   string       tag_q[$];
   initial forever begin
      @(negedge clk); #1;
      if (rst_n && cpu_valid && cpu_ready && !cpu_write) begin
         if (exp_q.size() == 0) check("scoreboard-empty", cpu_rdata, 32'hx);
         else check(tag_q.pop_front(), cpu_rdata, exp_q.pop_front());
      end
   end

   task automatic xfer(bit wr, logic [15:0] a, logic [31:0] wd, logic [31:0] exp,
                       string tag, output int waits);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = wd;
      if (!wr) begin exp_q.push_back(exp); tag_q.push_back(tag); end
      waits = 0;
      #1;
      while (!cpu_ready) begin @(negedge clk); #1; waits++; end
      @(negedge clk);
      cpu_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      int w, n0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R10 reset state
      check("R10 swap_en", {31'b0, swap_en}, 32'd0);
      check("R10 bar0_err", {31'b0, bar0_err}, 32'd0);
      check("R10 swap_base", swap_base, 32'd0);
      xfer(0, 16'hF010, 0, 32'd0, "R10 BAR0 reset", w);
      xfer(0, 16'hF014, 0, 32'd0, "R10 BAR1 reset", w);

      // R2 identity, one cycle; R11 priority over dn_present
      n0 = nreq;
      xfer(0, 16'hF000, 0, 32'h401310EE, "R2 bridge identity", w);
      check("R2 bridge single cycle", w, 0);
      check("R11 no downstream for bridge", nreq, n0);
      // R1 offset bit 11 ignored
      xfer(0, 16'hF800, 0, 32'h401310EE, "R1 bit11 ignored", w);
      // R7 other bridge registers
      xfer(1, 16'hF03C, 32'hFFFF_FFFF, 0, "", w);
      xfer(0, 16'hF03C, 0, 32'd0, "R7 unused reg reads 0", w);
      xfer(0, 16'hF008, 0, 32'd0, "R7 class reg reads 0", w);

      // R3 absent slot reads
      n0 = nreq;
      xfer(0, 16'h3000, 0, 32'hFFFF_FFFF, "R3 absent identity", w);
      check("R3 absent single cycle", w, 0);
      xfer(0, 16'h3110, 0, 32'd0, "R3 absent other reg", w);
      // R4 absent write discarded
      xfer(1, 16'h4020, 32'h1234_5678, 0, "", w);
      check("R4 absent write single cycle", w, 0);
      check("R4/R3 no downstream requests", nreq, n0);

      // R8 forwarded read, delay 0 and 5; R1 fields
      rsp_delay = 0; n0 = nreq;
      xfer(0, 16'h2824, 0, slot_data(4'd2, 3'd0, 8'h24), "R8 fwd read delay0", w);
      check("R8 one request", nreq, n0 + 1);
      check("R1 dev field", {28'b0, cap_dev}, 32'd2);
      check("R1 func field", {29'b0, cap_func}, 32'd0);
      check("R1 reg field", {24'b0, cap_reg}, 32'h24);
      check("R8 delay0 waits", w, 1);
      rsp_delay = 5;
      xfer(0, 16'h9340, 0, slot_data(4'd9, 3'd3, 8'h40), "R8 fwd read delay5", w);
      check("R8 delay5 waits", w, 6);
      // R8 forwarded write
      rsp_delay = 2;
      xfer(1, 16'h9204, 32'hCAFE_0042, 0, "", w);
      check("R8 write flag", {31'b0, cap_wr}, 32'd1);
      check("R8 write data", cap_wdata, 32'hCAFE_0042);
      check("R1 write func", {29'b0, cap_func}, 32'd2);
      check("R8 write waits", w, 3);
      // R11: dev 15 fn 1 is external
      rsp_delay = 0;
      xfer(0, 16'hF100, 0, slot_data(4'd15, 3'd1, 8'h00), "R11 dev15 fn1 forwarded", w);

      // R9 timeout and boundary
      rsp_delay = -1;
      xfer(0, 16'h2000, 0, 32'hFFFF_FFFF, "R9 timeout all ones", w);
      check("R9 timeout waits", w, 255);
      rsp_delay = 254;
      xfer(0, 16'h2008, 0, slot_data(4'd2, 3'd0, 8'h08), "R9 response on last cycle", w);
      check("R9 boundary waits", w, 255);
      rsp_delay = 0;

      // R5 BAR0 and error flag
      xfer(1, 16'hF010, 32'h0000_1000, 0, "", w);
      #1; check("R5 err set", {31'b0, bar0_err}, 32'd1);
      xfer(0, 16'hF010, 0, 32'h0000_1000, "R5 BAR0 stored", w);
      @(negedge clk); err_clear = 1'b1; @(negedge clk); err_clear = 1'b0; #1;
      check("R5 err cleared", {31'b0, bar0_err}, 32'd0);
      xfer(1, 16'hF010, 32'h0, 0, "", w);
      #1; check("R5 zero keeps err low", {31'b0, bar0_err}, 32'd0);
      xfer(0, 16'hF010, 0, 32'h0, "R5 BAR0 zero stored", w);

      // R6 BAR1 write-once
      xfer(1, 16'hF014, 32'h0, 0, "", w);
      #1; check("R6 zero write enables", {31'b0, swap_en}, 32'd1);
      xfer(1, 16'hF014, 32'h2000_0000, 0, "", w);
      #1; check("R6 base latched", swap_base, 32'h2000_0000);
      xfer(1, 16'hF014, 32'h3000_0000, 0, "", w);
      #1; check("R6 second write ignored", swap_base, 32'h2000_0000);
      xfer(0, 16'hF014, 0, 32'h2000_0000, "R6 BAR1 readback", w);
      check("R6 enable held", {31'b0, swap_en}, 32'd1);

      repeat (4) @(negedge clk);
      check("scoreboard drained", exp_q.size(), 0);
      finish_run();
   end
endmodule